// File: doc/BRIEF.md
# Two-Wire Target Receive Front End

This block is the bit-level receive side of a target on a two-wire serial bus (clock line and open-drain data line). It samples both lines on a fast system clock, passes each through a synchronizer and a spike filter, and recognises start and stop framing from the filtered levels. Between a start and a stop it shifts in 8-bit words, most significant bit first, on each rising edge of the bus clock, and acknowledges every word by pulling the data line low through the ninth bus clock.

The layers above receive a one-cycle word strobe with the received word, one-cycle start and stop pulses, a pull-down enable for the external open-drain data driver, and a standby flag. Standby is set out of reset, cleared by a start, and set again after a stop once the `busy_internal` input shows that no internal operation is still in progress.

Top module: `twowire_rx_front`

## Requirements
- R1: Each line passes through a SYNC_STAGES-deep synchronizer and then a filter whose output takes a new level only after the synchronized input has held that level for FILT_TICKS consecutive system clocks; any pulse shorter than that has no effect on the outputs.
- R2: A fall of filtered data while filtered clock is high, and was high the cycle before, produces `start_pulse` high for exactly one system clock.
- R3: A rise of filtered data while filtered clock is high, and was high the cycle before, produces `stop_pulse` high for exactly one system clock and ends any transfer in progress.
- R4: Data changes while the filtered clock is low are never reported as start or stop; data bits are taken only at the rising edge of the filtered clock.
- R5: After the eighth data bit of a word, `byte_valid` is high for exactly one clock, with `byte_data` holding the word and the first bit received at bit 7.
- R6: `sda_pull` goes high on the cycle after the falling bus-clock edge that ends the eighth bit and stays high until the cycle after the next falling bus-clock edge, which ends the ninth (acknowledge) clock; during that ninth clock no data bit is taken.
- R7: A start arriving in the middle of a word discards the partially shifted bits without any strobe, and the next eight bits form a new word.
- R8: `standby` is 1 out of reset and goes to 0 on the cycle after a start pulse.
- R9: After a stop, `standby` goes to 1 on the first clock at which `busy_internal` is sampled low; while it stays high, `standby` stays 0.
- R10: Bus clocks seen before the first start, or after a stop, produce no word strobe and no pull-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| busy_internal | input | 1 | High while an internal operation is pending; holds off standby |
| byte_valid | output | 1 | One-cycle strobe: a word has been received |
| byte_data | output | WORD_BITS | Last received word, first bit in the top position |
| start_pulse | output | 1 | One-cycle pulse on a start condition |
| stop_pulse | output | 1 | One-cycle pulse on a stop condition |
| sda_pull | output | 1 | Enable for the open-drain pull-down of the data line |
| standby | output | 1 | Target is idle in its low-power state |

## Verification
On every cycle the assertions check that start, stop and word strobes last one clock, that the filter holds its level whenever the synchronized input agrees with it, that the pull-down only begins while the filtered clock is low, that standby never rises while the busy input was high, and that a start always clears standby. Which words come out, the exact cycle at which each pulse, strobe and pull-down appears, the rejection of short spikes, and the discarding of a partial word on a repeated start can only be shown by the bench, which runs a behavioural model of the lines and the protocol beside the design and compares every output on every clock.

// File: rtl/twr_pkg.sv
package twr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE    = 2'd0,
      RX_SHIFT   = 2'd1,
      RX_ACKWAIT = 2'd2,
      RX_ACKDRV  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/twr_line_filter.sv
module twr_line_filter #(
   parameter int STAGES     = 2,
   parameter int TICKS      = 4,
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o
);
   localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LIM = CW'(TICKS - 1);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twr_line_filter: STAGES must be at least 2");
      end
      if (TICKS < 2) begin : g_bad_ticks
         $error("twr_line_filter: TICKS must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic [CW-1:0]     cnt_q;
   logic              sync_out;

   assign sync_out = sync_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {STAGES{IDLE_LEVEL}};
      else        sync_q <= {sync_q[STAGES-2:0], raw_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= IDLE_LEVEL;
         cnt_q   <= '0;
      end else if (sync_out == level_o) begin
         cnt_q <= '0;
      end else if (cnt_q == LIM) begin
         level_o <= sync_out;
         cnt_q   <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: while the synchronized input agrees with the output, the output holds
   assert_filt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_out == level_o) |=> $stable(level_o));
endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_o,
   output logic stop_o,
   output logic clk_rise_o,
   output logic clk_fall_o
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   logic clk_held_high;
   assign clk_held_high = scl_f & scl_d;
   assign start_o    = clk_held_high & sda_d & ~sda_f;
   assign stop_o     = clk_held_high & ~sda_d & sda_f;
   assign clk_rise_o = scl_f & ~scl_d;
   assign clk_fall_o = ~scl_f & scl_d;

   assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
   assert_stop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !stop_o);
endmodule

// File: rtl/twowire_rx_front.sv
module twowire_rx_front #(
   parameter int FILT_TICKS  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int WORD_BITS   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic                 busy_internal,
   output logic                 byte_valid,
   output logic [WORD_BITS-1:0] byte_data,
   output logic                 start_pulse,
   output logic                 stop_pulse,
   output logic                 sda_pull,
   output logic                 standby
);
   import twr_pkg::*;

   localparam int NLINES = 2;
   localparam int BCW    = $clog2(WORD_BITS);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_BITS - 1);

   generate
      if (WORD_BITS < 2) begin : g_bad_word
         $error("twowire_rx_front: WORD_BITS must be at least 2");
      end
   endgenerate

   // index 0 = clock line, index 1 = data line
   logic [NLINES-1:0] raw_lines, filt_lines;
   assign raw_lines = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         twr_line_filter #(
            .STAGES    (SYNC_STAGES),
            .TICKS     (FILT_TICKS),
            .IDLE_LEVEL(1'b1)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .level_o(filt_lines[g])
         );
      end
   endgenerate

   logic scl_f, sda_f, clk_rise, clk_fall;
   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   twr_bus_events u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .start_o   (start_pulse),
      .stop_o    (stop_pulse),
      .clk_rise_o(clk_rise),
      .clk_fall_o(clk_fall)
   );

   rx_state_t            state_q;
   logic [BCW-1:0]       bit_q;
   logic [WORD_BITS-1:0] shift_q;
   logic [WORD_BITS-1:0] shift_nx;
   logic                 stop_wait_q;

   assign shift_nx = {shift_q[WORD_BITS-2:0], sda_f};
   assign sda_pull = (state_q == RX_ACKDRV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RX_IDLE;
         bit_q      <= '0;
         shift_q    <= '0;
         byte_data  <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (start_pulse) begin
            state_q <= RX_SHIFT;
            bit_q   <= '0;
            shift_q <= '0;
         end else if (stop_pulse) begin
            state_q <= RX_IDLE;
            bit_q   <= '0;
         end else begin
            case (state_q)
               RX_SHIFT: if (clk_rise) begin
                  shift_q <= shift_nx;
                  if (bit_q == LAST_BIT) begin
                     byte_data  <= shift_nx;
                     byte_valid <= 1'b1;
                     bit_q      <= '0;
                     state_q    <= RX_ACKWAIT;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
               RX_ACKWAIT: if (clk_fall) state_q <= RX_ACKDRV;
               RX_ACKDRV:  if (clk_fall) state_q <= RX_SHIFT;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         standby     <= 1'b1;
         stop_wait_q <= 1'b0;
      end else if (start_pulse) begin
         standby     <= 1'b0;
         stop_wait_q <= 1'b0;
      end else if (stop_pulse || stop_wait_q) begin
         if (!busy_internal) begin
            standby     <= 1'b1;
            stop_wait_q <= 1'b0;
         end else begin
            stop_wait_q <= 1'b1;
         end
      end
   end

   assert_word_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);
   assert_pull_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_f);
   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !standby);
   assert_standby_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(standby) |-> !$past(busy_internal));
   assert_word_in_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(state_q) == RX_SHIFT);
endmodule

// File: tb/twowire_rx_front_tb.sv
module twowire_rx_front_tb;
   localparam int N = 4;
   localparam int S = 2;
   localparam int H = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic sda_i;
   logic byte_valid, start_pulse, stop_pulse, sda_pull, standby;
   logic [7:0] byte_data;

   always #5 clk = ~clk;

   assign sda_i = sda_m & ~sda_pull;

   twowire_rx_front #(.FILT_TICKS(N), .SYNC_STAGES(S), .WORD_BITS(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i),
      .busy_internal(busy), .byte_valid(byte_valid), .byte_data(byte_data),
      .start_pulse(start_pulse), .stop_pulse(stop_pulse),
      .sda_pull(sda_pull), .standby(standby));

   int n_cmp = 0, n_bad = 0;
   int n_start = 0, n_stop = 0;
   logic [7:0] got_q[$];
   logic [7:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit q_scl[$], q_sda[$];
   bit m_fs, m_fd, m_ps, m_pd;
   int run_s, run_d;
   int m_st;        // 0 idle, 1 shifting, 2 waiting fall, 3 pulling low
   int m_bits;
   bit [7:0] m_sh, m_data;
   bit m_valid, m_sb, m_wait;

   function automatic bit f_start(); return m_fs & m_ps & m_pd & ~m_fd; endfunction
   function automatic bit f_stop();  return m_fs & m_ps & ~m_pd & m_fd; endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q_scl = {}; q_sda = {};
         for (int i = 0; i < S; i++) begin q_scl.push_back(1'b1); q_sda.push_back(1'b1); end
         m_fs = 1; m_fd = 1; m_ps = 1; m_pd = 1; run_s = 0; run_d = 0;
         m_st = 0; m_bits = 0; m_sh = 0; m_data = 0; m_valid = 0; m_sb = 1; m_wait = 0;
      end else begin
         bit raw_d, st, sp, rise, fall, so;
         raw_d = sda_m & ~(m_st == 3);
         st = f_start(); sp = f_stop();
         rise = m_fs & ~m_ps; fall = ~m_fs & m_ps;
         m_valid = 0;
         if (st) begin m_st = 1; m_bits = 0; m_sh = 0; end
         else if (sp) begin m_st = 0; m_bits = 0; end
         else if (m_st == 1 && rise) begin
            m_sh = {m_sh[6:0], m_fd};
            m_bits++;
            if (m_bits == 8) begin m_data = m_sh; m_valid = 1; m_bits = 0; m_st = 2; end
         end else if (m_st == 2 && fall) m_st = 3;
         else if (m_st == 3 && fall) m_st = 1;
         if (st) begin m_sb = 0; m_wait = 0; end
         else if (sp || m_wait) begin
            if (!busy) begin m_sb = 1; m_wait = 0; end else m_wait = 1;
         end
         m_ps = m_fs; m_pd = m_fd;
         so = q_scl[0];
         if (so == m_fs) run_s = 0; else if (run_s == N-1) begin m_fs = so; run_s = 0; end else run_s++;
         so = q_sda[0];
         if (so == m_fd) run_d = 0; else if (run_d == N-1) begin m_fd = so; run_d = 0; end else run_d++;
         q_scl.push_back(scl_m); void'(q_scl.pop_front());
         q_sda.push_back(raw_d); void'(q_sda.pop_front());
      end
   end

   bit run_cmp = 0;
   always @(negedge clk) if (run_cmp) begin
      chk(start_pulse === f_start(), "R2 start_pulse", start_pulse, f_start());
      chk(stop_pulse === f_stop(), "R3 stop_pulse", stop_pulse, f_stop());
      chk(byte_valid === m_valid, "R5 byte_valid", byte_valid, m_valid);
      if (m_valid) chk(byte_data === m_data, "R5 byte_data", byte_data, m_data);
      chk(sda_pull === (m_st == 3), "R6 sda_pull", sda_pull, (m_st == 3));
      chk(standby === m_sb, "R8/R9 standby", standby, m_sb);
      if (start_pulse) n_start++;
      if (stop_pulse) n_stop++;
      if (byte_valid) got_q.push_back(byte_data);
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

   task automatic bus_start();   // from scl high, sda high
      sda_m = 1'b0; cyc(H); scl_m = 1'b0; cyc(H);
   endtask

   task automatic bus_restart(); // from scl low
      cyc(4); sda_m = 1'b1; cyc(H); scl_m = 1'b1; cyc(H); sda_m = 1'b0; cyc(H); scl_m = 1'b0; cyc(H);
   endtask

   task automatic bus_stop();    // from scl low
      cyc(4); sda_m = 1'b0; cyc(H); scl_m = 1'b1; cyc(H); sda_m = 1'b1; cyc(H);
   endtask

   task automatic send_bit(input bit b, input bit spiky);
      cyc(4); sda_m = b; cyc(H - 4); scl_m = 1'b1;
      if (spiky) begin
         cyc(5); scl_m = 1'b0; cyc(2); scl_m = 1'b1;        // short low spike on clock
         cyc(3); sda_m = ~b; cyc(2); sda_m = b; cyc(H - 12); // short spike on data
      end else cyc(H);
      scl_m = 1'b0;
   endtask

   task automatic send_word(input logic [7:0] v, input bit spiky);
      for (int i = 7; i >= 0; i--) send_bit(v[i], spiky);
      send_bit(1'b1, 1'b0);   // acknowledge clock, data released
      exp_q.push_back(v);
   endtask

   task automatic check_words(input string req);
      chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
      while (got_q.size() > 0 && exp_q.size() > 0) begin
         logic [7:0] a, e;
         a = got_q.pop_front(); e = exp_q.pop_front();
         chk(a === e, req, a, e);
      end
      got_q = {}; exp_q = {};
   endtask

   bit done = 0;
   initial begin
      cyc(4);
      chk(standby === 1'b1, "R8 reset standby", standby, 1);
      chk(sda_pull === 1'b0 && byte_valid === 1'b0, "R8 reset outputs", sda_pull, 0);
      rst_n = 1'b1;
      run_cmp = 1;
      cyc(10);

      // R10: clocks before any start
      scl_m = 1'b0; cyc(H);
      for (int i = 0; i < 9; i++) send_bit(i[0], 1'b0);
      cyc(4); sda_m = 1'b1; cyc(4); scl_m = 1'b1; cyc(H);
      check_words("R10 no word before start");
      chk(n_start == 0, "R4 no start from low-clock data", n_start, 0);

      // R1: short data spike with clock high
      sda_m = 1'b0; cyc(3); sda_m = 1'b1; cyc(H);
      chk(n_start == 0, "R1 spike rejected", n_start, 0);

      // R5/R6: two words then stop
      bus_start();
      chk(n_start == 1, "R2 start counted", n_start, 1);
      chk(standby === 1'b0, "R8 standby cleared", standby, 0);
      send_word(8'hA5, 1'b0);
      send_word(8'h3C, 1'b0);
      bus_stop(); cyc(4);
      check_words("R5 two words");
      chk(n_stop == 1, "R3 stop counted", n_stop, 1);
      chk(standby === 1'b1, "R9 standby after stop", standby, 1);

      // R1: spikes on both lines during bits
      bus_start();
      send_word(8'h96, 1'b1);
      send_word(8'h00, 1'b0);
      send_word(8'hFF, 1'b1);
      bus_stop(); cyc(4);
      check_words("R1 words despite spikes");

      // R7: repeated start after four bits
      bus_start();
      for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
      bus_restart();
      send_word(8'h81, 1'b0);
      check_words("R7 partial word discarded");

      // R9: stop while busy
      busy = 1'b1;
      bus_stop(); cyc(H);
      chk(standby === 1'b0, "R9 held off while busy", standby, 0);
      busy = 1'b0; cyc(3);
      chk(standby === 1'b1, "R9 standby after busy drops", standby, 1);

      // R10: clocks after stop ignored
      scl_m = 1'b0; cyc(H);
      for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b0);
      cyc(4); sda_m = 1'b1; cyc(4); scl_m = 1'b1; cyc(H);
      check_words("R10 no word after stop");

      run_cmp = 0;
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule